// File: doc/BRIEF.md
# Bit-Field Clear Set Extract Unit

This unit is one registered stage of a 32-bit datapath that works on a bit field inside a source word. It supports four operations: forcing the field to zeros, forcing it to ones, pulling the field out with sign extension, and pulling it out with zero extension. Every operation uses two 5-bit bound values, called `pos_a` and `pos_b`. They come either from two immediate inputs or from the low ten bits of a control word.

For clear and set, `pos_a` is the lowest bit of the field and `pos_b` is the highest. For the two extract operations, the source is first shifted left by `pos_a` and then shifted right by `pos_b`. The right shift is arithmetic for the signed form and logical for the unsigned form. To extract bits M down to L, choose `pos_a = 31 - M` and `pos_b = pos_a + L`.

The unit raises an invalid flag next to the result in two cases:
- a register-form control word has non-zero upper bits;
- a clear or set has a highest bit that is not above its lowest bit.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst` is high, and after its release, `out_valid`, `result` and `bad_operand` read 0 until the first accepted operation.
- R2: `out_valid` goes high exactly one clock after a cycle with `in_valid` high. In any cycle without `in_valid`, `result` and `bad_operand` keep their values.
- R3: Op code 2'b00 (clear) with `pos_b > pos_a` forces bits `pos_a`..`pos_b` (inclusive) to 0. All other bits copy `src`.
- R4: Op code 2'b01 (set) with `pos_b > pos_a` forces bits `pos_a`..`pos_b` (inclusive) to 1. All other bits copy `src`.
- R5: Clear or set with `pos_b <= pos_a` returns `src` unchanged and raises `bad_operand`.
- R6: Op code 2'b10 (signed extract) returns `src` shifted left by `pos_a`, then arithmetically shifted right by `pos_b`.
- R7: Op code 2'b11 (unsigned extract) uses the same left shift, followed by a logical right shift by `pos_b`.
- R8: When `use_reg` is 1, `pos_b` is `ctrl[4:0]` and `pos_a` is `ctrl[9:5]`, and the immediates are ignored.
- R9: When `use_reg` is 1 and any of `ctrl[31:10]` is non-zero, `bad_operand` is raised. The result is still computed from `ctrl[9:0]`.
- R10: When `use_reg` is 0, `ctrl` has no effect. Extract operations in this form never raise `bad_operand`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands this cycle |
| op | input | 2 | 00 clear, 01 set, 10 signed extract, 11 unsigned extract |
| src | input | 32 | Source data word |
| imm_a | input | 5 | Immediate `pos_a` (field LSB, or left shift) |
| imm_b | input | 5 | Immediate `pos_b` (field MSB, or right shift) |
| ctrl | input | 32 | Control word for register form |
| use_reg | input | 1 | 1 takes the bounds from `ctrl` |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | 32 | Registered result |
| bad_operand | output | 1 | Invalid-operand flag paired with `result` |

## Verification
The hardest case to reach from the ports is an invalid flag raised for a reason unrelated to the data path actually taken. One example is a register-form control word whose upper bits are set while its low ten bits form legal bounds. Here the result must still come out correct while the flag is high.

The stimulus table builds its control words with stray bits at bit 10 and bit 31 around legal packed bounds. It also uses an all-ones control word in immediate form, which checks that the flag comes only from the selected bound source.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int DATA_W = 32;
    localparam int POS_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OP_CLR  = 2'b00,
        OP_SET  = 2'b01,
        OP_SEXT = 2'b10,
        OP_ZEXT = 2'b11
    } bf_op_e;

    typedef struct packed {
        logic [POS_W-1:0] pos_a;
        logic [POS_W-1:0] pos_b;
        logic             ctrl_bad;
    } bounds_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bad;
    } bf_res_t;

endpackage

// File: rtl/bfu_bounds.sv
module bfu_bounds
    import bfu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = POS_W
) (
    input  logic          use_reg,
    input  logic [PW-1:0] imm_a,
    input  logic [PW-1:0] imm_b,
    input  logic [DW-1:0] ctrl,
    output bounds_t       bnd
);
    localparam int PACK_W = 2 * PW;

    always_comb begin
        if (use_reg) begin
            bnd.pos_b    = ctrl[PW-1:0];
            bnd.pos_a    = ctrl[PACK_W-1:PW];
            bnd.ctrl_bad = |ctrl[DW-1:PACK_W];
        end else begin
            bnd.pos_b    = imm_b;
            bnd.pos_a    = imm_a;
            bnd.ctrl_bad = 1'b0;
        end
    end
endmodule

// File: rtl/bfu_fieldop.sv
module bfu_fieldop
    import bfu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = POS_W
) (
    input  logic [DW-1:0] src,
    input  logic [PW-1:0] lo,
    input  logic [PW-1:0] hi,
    input  logic          set_mode,
    output logic [DW-1:0] dout,
    output logic          order_bad
);
    logic [DW-1:0] mask;

    for (genvar i = 0; i < DW; i++) begin : g_mask
        localparam logic [PW-1:0] IDX = PW'(i);
        assign mask[i] = (IDX >= lo) && (IDX <= hi);
    end

    assign order_bad = !(hi > lo);

    always_comb begin
        if (order_bad)
            dout = src;
        else if (set_mode)
            dout = src | mask;
        else
            dout = src & ~mask;
    end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract
    import bfu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = POS_W
) (
    input  logic [DW-1:0] src,
    input  logic [PW-1:0] lshift,
    input  logic [PW-1:0] rshift,
    input  logic          sign_mode,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] shl;

    assign shl = src << lshift;

    always_comb begin
        if (sign_mode)
            dout = DW'($signed(shl) >>> rshift);
        else
            dout = shl >> rshift;
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    op,
    input  logic [DW-1:0] src,
    input  logic [PW-1:0] imm_a,
    input  logic [PW-1:0] imm_b,
    input  logic [DW-1:0] ctrl,
    input  logic          use_reg,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          bad_operand
);
    bf_op_e        op_e;
    bounds_t       bnd;
    logic [DW-1:0] field_res;
    logic [DW-1:0] ext_res;
    logic          order_bad;
    bf_res_t       nxt;
    bf_res_t       res_q;
    logic          vld_q;

    assign op_e = bf_op_e'(op);

    bfu_bounds #(.DW(DW), .PW(PW)) u_bounds (
        .use_reg (use_reg),
        .imm_a   (imm_a),
        .imm_b   (imm_b),
        .ctrl    (ctrl),
        .bnd     (bnd)
    );

    bfu_fieldop #(.DW(DW), .PW(PW)) u_field (
        .src       (src),
        .lo        (bnd.pos_a),
        .hi        (bnd.pos_b),
        .set_mode  (op_e == OP_SET),
        .dout      (field_res),
        .order_bad (order_bad)
    );

    bfu_extract #(.DW(DW), .PW(PW)) u_ext (
        .src       (src),
        .lshift    (bnd.pos_a),
        .rshift    (bnd.pos_b),
        .sign_mode (op_e == OP_SEXT),
        .dout      (ext_res)
    );

    always_comb begin
        case (op_e)
            OP_CLR, OP_SET: begin
                nxt.data = field_res;
                nxt.bad  = bnd.ctrl_bad | order_bad;
            end
            default: begin
                nxt.data = ext_res;
                nxt.bad  = bnd.ctrl_bad;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= nxt;
        end
    end

    assign out_valid   = vld_q;
    assign result      = res_q.data;
    assign bad_operand = res_q.bad;
endmodule

// File: rtl/bfu_chk.sv
module bfu_chk #(
    parameter int DW = 32,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    op,
    input logic [DW-1:0] src,
    input logic [PW-1:0] imm_a,
    input logic [PW-1:0] imm_b,
    input logic [DW-1:0] ctrl,
    input logic          use_reg,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic          bad_operand
);
    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result) && $stable(bad_operand));

    // R3
    clear_only_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00) |=> ((result & ~$past(src)) == '0));

    // R4
    set_only_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b01) |=> (($past(src) & ~result) == '0));

    // R5
    bad_order_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_reg && !op[1] && imm_b <= imm_a)
        |=> bad_operand && result == $past(src));

    // R9
    ctrl_upper_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && use_reg && |ctrl[DW-1:2*PW]) |=> bad_operand);

    // R10
    imm_extract_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_reg && op[1]) |=> !bad_operand);
endmodule

bind bitfield_unit bfu_chk #(.DW(DW), .PW(PW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op          (op),
    .src         (src),
    .imm_a       (imm_a),
    .imm_b       (imm_b),
    .ctrl        (ctrl),
    .use_reg     (use_reg),
    .out_valid   (out_valid),
    .result      (result),
    .bad_operand (bad_operand)
);

// File: tb/tb_bitfield_unit.sv
module tb_bitfield_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] src;
        logic [4:0]  a;
        logic [4:0]  b;
        logic [31:0] ctrl;
        logic        use_reg;
        logic [31:0] exp_res;
        logic        exp_bad;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // R3 clear bits 4..11
        '{2'b00, 32'hFFFFFFFF, 5'd4,  5'd11, 32'h0, 1'b0, 32'hFFFFF00F, 1'b0, 8'd3},
        // R3 clear whole word
        '{2'b00, 32'h12345678, 5'd0,  5'd31, 32'h0, 1'b0, 32'h00000000, 1'b0, 8'd3},
        // R4 set bits 8..15
        '{2'b01, 32'h00000000, 5'd8,  5'd15, 32'h0, 1'b0, 32'h0000FF00, 1'b0, 8'd4},
        // R4 set top two bits
        '{2'b01, 32'h80000001, 5'd30, 5'd31, 32'h0, 1'b0, 32'hC0000001, 1'b0, 8'd4},
        // R5 equal bounds
        '{2'b00, 32'hFFFFFFFF, 5'd7,  5'd7,  32'h0, 1'b0, 32'hFFFFFFFF, 1'b1, 8'd5},
        // R5 reversed bounds on set
        '{2'b01, 32'h0000AAAA, 5'd9,  5'd3,  32'h0, 1'b0, 32'h0000AAAA, 1'b1, 8'd5},
        // R6 bits 19..11, negative field
        '{2'b10, 32'h00080000, 5'd12, 5'd23, 32'h0, 1'b0, 32'hFFFFFF00, 1'b0, 8'd6},
        // R6 bits 19..11, positive field
        '{2'b10, 32'h0007F800, 5'd12, 5'd23, 32'h0, 1'b0, 32'h000000FF, 1'b0, 8'd6},
        // R6 single top bit spread
        '{2'b10, 32'h80000000, 5'd0,  5'd31, 32'h0, 1'b0, 32'hFFFFFFFF, 1'b0, 8'd6},
        // R7 bits 19..11 zero extended
        '{2'b11, 32'h00080000, 5'd12, 5'd23, 32'h0, 1'b0, 32'h00000100, 1'b0, 8'd7},
        // R7 zero shifts pass through
        '{2'b11, 32'hDEADBEEF, 5'd0,  5'd0,  32'h0, 1'b0, 32'hDEADBEEF, 1'b0, 8'd7},
        // R8 register form clear, immediates ignored
        '{2'b00, 32'hFFFFFFFF, 5'd0,  5'd0,  32'h0000008B, 1'b1, 32'hFFFFF00F, 1'b0, 8'd8},
        // R8 register form unsigned extract
        '{2'b11, 32'h00080000, 5'd1,  5'd2,  32'h00000197, 1'b1, 32'h00000100, 1'b0, 8'd8},
        // R9 stray bit 10 on clear
        '{2'b00, 32'hFFFFFFFF, 5'd0,  5'd0,  32'h0000048B, 1'b1, 32'hFFFFF00F, 1'b1, 8'd9},
        // R9 stray bit 31 on extract
        '{2'b11, 32'h00080000, 5'd0,  5'd0,  32'h80000197, 1'b1, 32'h00000100, 1'b1, 8'd9},
        // R5 register form reversed bounds
        '{2'b01, 32'h00000000, 5'd0,  5'd0,  32'h00000123, 1'b1, 32'h00000000, 1'b1, 8'd5},
        // R10 ctrl ignored in immediate form
        '{2'b11, 32'h00080000, 5'd12, 5'd23, 32'hFFFFFFFF, 1'b0, 32'h00000100, 1'b0, 8'd10},
        // R10 signed extract with junk ctrl
        '{2'b10, 32'h7FFFFFFF, 5'd0,  5'd31, 32'hFFFFFFFF, 1'b0, 32'h00000000, 1'b0, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [31:0] src = '0;
    logic [4:0]  imm_a = '0;
    logic [4:0]  imm_b = '0;
    logic [31:0] ctrl = '0;
    logic        use_reg = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        bad_operand;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] held;

    bitfield_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .src(src),
        .imm_a(imm_a), .imm_b(imm_b), .ctrl(ctrl), .use_reg(use_reg),
        .out_valid(out_valid), .result(result), .bad_operand(bad_operand)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        op = v.op; src = v.src; imm_a = v.a; imm_b = v.b;
        ctrl = v.ctrl; use_reg = v.use_reg; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check($sformatf("R%0d result", v.req), result, v.exp_res);
        check($sformatf("R%0d bad", v.req), {31'b0, bad_operand}, {31'b0, v.exp_bad});
        check("R2 strobe", {31'b0, out_valid}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check("R1 valid in reset", {31'b0, out_valid}, 32'd0);
        check("R1 result in reset", result, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 flag after reset", {31'b0, bad_operand}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2 hold: new operands without in_valid change nothing
        held = result;
        @(negedge clk);
        op = 2'b01; src = 32'h0; imm_a = 5'd0; imm_b = 5'd31; use_reg = 1'b0;
        @(negedge clk);
        check("R2 idle strobe", {31'b0, out_valid}, 32'd0);
        check("R2 result held", result, held);
        check("R2 flag held", {31'b0, bad_operand}, 32'd0);

        // R1 reset after a non-zero result
        run_vec(VECS[0]);
        rst = 1'b1;
        @(negedge clk);
        check("R1 result cleared", result, 32'd0);
        check("R1 strobe cleared", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule